// File: doc/BRIEF.md
# Halted-Read Bus Injection Unit

This block lends the processor's memory bus to a second agent for one read at a time. It does this without a bus-grant handshake. When a request arrives, the unit pulls the processor's ready input low. It then watches the processor's read/write indicator. Write cycles run to completion even while ready is low, so the unit keeps waiting through them. Once the processor has stalled on a read, it keeps repeating that read. The unit then points the memory-side address multiplexer at the requested address for exactly one cycle and captures the returned data. For one further cycle it puts the processor's own address back on the bus. Only after that does it release ready. From the processor's point of view, its stalled read simply finishes late.

A requester gives an address with a valid strobe and receives a same-cycle acknowledge when the request is taken. It receives the data later with a single-cycle valid pulse. A second request is refused until the previous injection has completed and ready has been high for at least one full cycle. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `rdinj_unit`

## Requirements
- R1: While reset is active, and for two clock edges after its release, `cpu_rdy` is 1, `mem_sel` is 0, `rsp_valid` is 0 and `req_ack` is 0.
- R2: With the unit idle and not cooling down, `req_valid` high gives `req_ack` high in the same cycle, and `cpu_rdy` is 0 from the next cycle on.
- R3: While ready is held low before the override, every cycle with `cpu_rw` = 0 (a write) leaves `mem_sel` at 0 in the next cycle. Any number of such cycles is waited through.
- R4: The first cycle with `cpu_rw` = 1 (a read) while ready is low and no override has happened yet is followed by exactly one cycle with `mem_sel` = 1.
- R5: Whenever `mem_sel` is 0, `mem_addr` equals `cpu_addr`.
- R6: The value on `bus_rdata` at the end of the override cycle appears on `rsp_data` in the next cycle, with `rsp_valid` high for that one cycle only. In that cycle `mem_sel` is 0 and `cpu_rdy` is still 0.
- R7: `cpu_rdy` returns to 1 in the cycle after the `rsp_valid` pulse.
- R8: `req_ack` stays 0 during an injection and during the first cycle in which `cpu_rdy` is high again. A request held high is therefore taken no earlier than the second ready-high cycle.
- R9: During the override cycle, `mem_addr` equals `req_addr` as sampled in the accepting cycle. Later changes on `req_addr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Injection request strobe |
| req_addr | input | ADDR_W | Address to read |
| req_ack | output | 1 | Request taken this cycle |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read result |
| rsp_data | output | DATA_W | Captured read data |
| cpu_addr | input | ADDR_W | Address presented by the processor |
| cpu_rw | input | 1 | Processor cycle type: 1 read, 0 write |
| bus_rdata | input | DATA_W | Data returned by memory |
| cpu_rdy | output | 1 | Ready input of the processor |
| mem_sel | output | 1 | Multiplexer select: 1 picks the injected address |
| mem_addr | output | ADDR_W | Address after the multiplexer |

## Verification
The first pattern holds the request high while the processor reads on every cycle. This gives back-to-back injections, so it exposes any error in the cooldown spacing or in the number of restore cycles. The second pattern inserts runs of zero to three write cycles before each read. This separates a unit that waits for a stalled read from one that overrides as soon as ready drops. The third pattern randomises every input each cycle, including a `req_addr` and `cpu_addr` that change during an injection. This shows whether the injected address is the one captured at acceptance, and whether the processor address passes through cleanly outside the override cycle.

// File: rtl/rdinj_pkg.sv
package rdinj_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HALT    = 2'd1,
    ST_OVR     = 2'd2,
    ST_RESTORE = 2'd3
  } rdinj_state_e;
endpackage

// File: rtl/rdinj_rst_sync.sv
module rdinj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rdinj_seq.sv
module rdinj_seq
  import rdinj_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic req_valid,
  input  logic cpu_is_read,
  output logic accept,
  output logic cap_data_en,
  output logic cpu_rdy,
  output logic mem_sel,
  output logic rsp_valid
);
  rdinj_state_e state_q, state_d;
  logic         cool_q, cool_d;

  always_comb begin
    state_d = state_q;
    cool_d  = cool_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cool_d = 1'b0;
        if (req_valid && !cool_q) begin
          accept  = 1'b1;
          state_d = ST_HALT;
        end
      end
      ST_HALT:    if (cpu_is_read) state_d = ST_OVR;
      ST_OVR:     state_d = ST_RESTORE;
      ST_RESTORE: begin
        state_d = ST_IDLE;
        cool_d  = 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cool_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cool_q  <= cool_d;
    end
  end

  assign cap_data_en = (state_q == ST_OVR);
  assign cpu_rdy     = (state_q == ST_IDLE);
  assign mem_sel     = (state_q == ST_OVR);
  assign rsp_valid   = (state_q == ST_RESTORE);
endmodule

// File: rtl/rdinj_capture.sv
module rdinj_capture #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (addr_en) addr_d = addr_in;
    if (data_en) data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/rdinj_addr_mux.sv
module rdinj_addr_mux #(
  parameter int ADDR_W = 24
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] inj_addr,
  output logic [ADDR_W-1:0] out_addr
);
  always_comb begin
    out_addr = sel ? inj_addr : cpu_addr;
  end
endmodule

// File: rtl/rdinj_unit.sv
module rdinj_unit #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ack,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_rdy,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr
);
  logic              rst_sync_n;
  logic              cap_data_en;
  logic [ADDR_W-1:0] inj_addr;

  rdinj_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rdinj_seq u_seq (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .req_valid   (req_valid),
    .cpu_is_read (cpu_rw),
    .accept      (req_ack),
    .cap_data_en (cap_data_en),
    .cpu_rdy     (cpu_rdy),
    .mem_sel     (mem_sel),
    .rsp_valid   (rsp_valid)
  );

  rdinj_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .addr_en (req_ack),
    .addr_in (req_addr),
    .data_en (cap_data_en),
    .data_in (bus_rdata),
    .addr_q  (inj_addr),
    .data_q  (rsp_data)
  );

  rdinj_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel      (mem_sel),
    .cpu_addr (cpu_addr),
    .inj_addr (inj_addr),
    .out_addr (mem_addr)
  );
endmodule

// File: rtl/rdinj_unit_chk.sv
module rdinj_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ack,
  input logic rsp_valid,
  input logic cpu_rw,
  input logic cpu_rdy,
  input logic mem_sel
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (cpu_rdy && !mem_sel && !rsp_valid && !req_ack));

  // R2
  accept_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (!cpu_rdy && !mem_sel));

  // R3
  write_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && !mem_sel && !rsp_valid && !cpu_rw) |=> !mem_sel);

  // R4
  read_overrides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && !mem_sel && !rsp_valid && cpu_rw) |=> mem_sel);

  // R4
  single_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |=> !mem_sel);

  // R6
  restore_after_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |=> (rsp_valid && !cpu_rdy));

  // R7
  release_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (cpu_rdy && !rsp_valid));

  // R8
  cooldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rdy) |-> !req_ack);
endmodule

bind rdinj_unit rdinj_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ack   (req_ack),
  .rsp_valid (rsp_valid),
  .cpu_rw    (cpu_rw),
  .cpu_rdy   (cpu_rdy),
  .mem_sel   (mem_sel)
);

// File: tb/rdinj_unit_bench.sv
module rdinj_unit_bench;
  localparam int AW = 24;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ack;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] cpu_addr;
  logic          cpu_rw;
  logic [DW-1:0] bus_rdata;
  logic          cpu_rdy;
  logic          mem_sel;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rdinj_unit #(.ADDR_W(AW), .DATA_W(DW)) u_rdinj_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .bus_rdata(bus_rdata),
    .cpu_rdy(cpu_rdy), .mem_sel(mem_sel), .mem_addr(mem_addr)
  );

  // Behavioural reference: 0 idle, 1 halted, 2 override, 3 restore
  int            m_st   = 0;
  int            m_sync = 0;
  bit            m_cool = 1'b1;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_st = 0; m_cool = 1'b1;
    end else if (m_sync < 2) begin
      m_sync++; m_st = 0; m_cool = 1'b1;
    end else begin
      case (m_st)
        0: begin
          if (req_valid && !m_cool) begin
            m_addr = req_addr;
            m_st   = 1;
          end
          m_cool = 1'b0;
        end
        1: if (cpu_rw) m_st = 2;
        2: begin m_data = bus_rdata; m_st = 3; end
        default: begin m_st = 0; m_cool = 1'b1; end
      endcase
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done) begin
      bit            in_rst;
      bit            e_sel;
      logic [AW-1:0] e_addr;
      in_rst = !rst_n || (m_sync < 2);
      e_sel  = (m_st == 2);
      e_addr = e_sel ? m_addr : cpu_addr;
      chk(in_rst ? "R1" : (m_st == 0 ? "R7" : "R2"), "cpu_rdy", 32'(cpu_rdy), 32'(m_st == 0));
      chk(in_rst ? "R1" : (m_st == 1 ? "R3" : "R4"), "mem_sel", 32'(mem_sel), 32'(e_sel));
      chk(in_rst ? "R1" : "R6", "rsp_valid", 32'(rsp_valid), 32'(m_st == 3));
      chk(in_rst ? "R1" : "R8", "req_ack", 32'(req_ack),
          32'(m_st == 0 && !m_cool && req_valid));
      chk(e_sel ? "R9" : "R5", "mem_addr", 32'(mem_addr), 32'(e_addr));
      if (m_st == 3) chk("R6", "rsp_data", 32'(rsp_data), 32'(m_data));
    end
  end

  task automatic drive(input bit v, input bit rw);
    @(negedge clk);
    req_valid = v;
    req_addr  = AW'($urandom);
    cpu_addr  = AW'($urandom);
    cpu_rw    = rw;
    bus_rdata = DW'($urandom);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int wl;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    cpu_addr = '0; cpu_rw = 1'b1; bus_rdata = '0;
    repeat (4) drive(1'b0, 1'b1);   // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    repeat (4) drive(1'b1, 1'b1);   // R1 sync release, R8 initial cooldown
    // back-to-back injections, processor always reading (R2, R4, R7, R8)
    repeat (60) drive(1'b1, 1'b1);
    // write runs of 0..3 before each read (R3)
    wl = 0;
    for (int i = 0; i < 300; i++) begin
      if (wl > 0) begin drive(1'b1, 1'b0); wl--; end
      else begin drive(1'b1, 1'b1); wl = $urandom_range(0, 3); end
    end
    // fully random inputs (R5, R6, R9)
    for (int i = 0; i < 3000; i++) drive(1'($urandom), 1'($urandom));
    repeat (4) drive(1'b0, 1'b1);
    @(negedge clk);
    #4;
    finish_run();
  end
endmodule